// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small microcontroller core. Each subroutine call or interrupt entry stores the address the core must come back to. Each subroutine or interrupt return takes back the newest stored address, and the core loads its program counter from it.

The block holds up to 16 addresses in a circular buffer and tracks how many are in use. Software has no path to read or write the stored addresses or the fill level.

The block also gates interrupt entry. While all 16 places are taken, a pending request is not acknowledged. It is acknowledged as soon as a return has freed a place. A call made while the stack is full is still accepted. It drops the oldest address, so the 16 newest are always kept.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: `empty_o`=1, `full_o`=0 and `underflow_o`=0. With `irq_req_i`=0, `irq_ack_o`=0.
- R2: A pop returns the newest pushed address that has not yet been popped. `pop_addr_o` shows that address combinationally while `pop_i` is high, and the pop takes effect at the clock edge. `push_i` and `pop_i` are never high in the same cycle.
- R3: Sixteen pushes with no pops raise `full_o` and clear `empty_o`. Popping every entry again restores `empty_o`=1.
- R4: A push while `full_o`=1 stores the new address and discards the oldest one. `full_o` stays at 1, and the following 16 pops return the 16 newest addresses in reverse order of pushing.
- R5: `irq_ack_o` follows `irq_req_i` while `full_o`=0. It is held at 0 while `full_o`=1.
- R6: After a pop from a full stack, a request that is still pending is acknowledged from the next cycle on.
- R7: A pop on an empty stack changes no state. During that cycle `pop_addr_o` shows the address given by the last successful pop, or 0 if there has been none since reset. `underflow_o` is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store `push_addr_i` (call or interrupt entry) |
| push_addr_i | input | ADDR_W | Return address to store |
| pop_i | input | 1 | Take the newest address (return) |
| pop_addr_o | output | ADDR_W | Address returned by a pop |
| irq_req_i | input | 1 | Pending unmasked interrupt request |
| irq_ack_o | output | 1 | Interrupt acknowledge, gated by fill level |
| full_o | output | 1 | All 16 places in use |
| empty_o | output | 1 | No address stored |
| underflow_o | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
Pushes and pops are tried in three orders:
- Short interleaved bursts show that the newest-first order holds across partial fills.
- A fill to exactly 16 followed by a full drain separates a correct depth from an off-by-one counter.
- Pushes beyond 16 followed by a full drain tell a stack that drops the oldest entry apart from one that drops the newest entry or stalls.

Empty pops are made both right after reset and after a drain. This shows whether the held address, the unchanged state and the one-cycle pulse behave as specified. The interrupt request is raised while the stack is not full, while it is full and across a return. This separates a gate on the fill level from an ungated acknowledge.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              irq_req_i,
  output logic              irq_ack_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              underflow_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     wr_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] last_q;
  logic              unf_q;

  wire [PW-1:0] top    = wr_q - 1'b1;
  wire          pop_ok = pop_i && !push_i && !empty_o;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign pop_addr_o  = empty_o ? last_q : slot_q[top];
  assign irq_ack_o   = irq_req_i && !full_o;
  assign underflow_o = unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      unf_q  <= 1'b0;
    end else begin
      unf_q <= pop_i && !push_i && empty_o;
      if (push_i) begin
        slot_q[wr_q] <= push_addr_i;
        wr_q         <= wr_q + 1'b1;
        if (!full_o) cnt_q <= cnt_q + 1'b1;
      end else if (pop_ok) begin
        wr_q   <= top;
        cnt_q  <= cnt_q - 1'b1;
        last_q <= slot_q[top];
      end
    end
  end

  a_r2_push_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
  a_r3_push_leaves_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> !empty_o);
  a_r4_full_holds_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i) |=> full_o);
  a_r5_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);
  a_r6_pop_frees_place: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && full_o) |=> !full_o);
  a_r7_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (underflow_o && empty_o));
  a_r7_stable_on_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> $stable(pop_addr_o));
endmodule

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;
  localparam int AW = 13;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, push_i = 0, pop_i = 0, irq_req_i = 0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic irq_ack_o, full_o, empty_o, underflow_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [AW-1:0] model[$];
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] last_pop = '0;

  always #5 clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .irq_req_i(irq_req_i),
    .irq_ack_o(irq_ack_o), .full_o(full_o), .empty_o(empty_o),
    .underflow_o(underflow_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pop_i && exp_q.size() > 0) begin
      logic [AW-1:0] e;
      e = exp_q.pop_front();
      chk(pop_addr_o == e, "R2 pop address", pop_addr_o, e);
    end
  end

  task automatic do_push(input logic [AW-1:0] a);
    @(posedge clk); #1;
    push_i = 1; push_addr_i = a;
    model.push_back(a);
    if (model.size() > DEPTH) void'(model.pop_front());
    @(posedge clk); #1;
    push_i = 0;
  endtask

  task automatic do_pop();
    logic [AW-1:0] e;
    if (model.size() > 0) begin
      e = model.pop_back();
      last_pop = e;
    end else e = last_pop;
    exp_q.push_back(e);
    @(posedge clk); #1;
    pop_i = 1;
    @(posedge clk); #1;
    pop_i = 0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    at_neg();
    chk(empty_o == 1, "R1 empty", empty_o, 1);
    chk(full_o == 0, "R1 full", full_o, 0);
    chk(underflow_o == 0, "R1 underflow", underflow_o, 0);
    chk(irq_ack_o == 0, "R1 ack", irq_ack_o, 0);

    // R7: empty pop right after reset shows 0
    do_pop();
    at_neg();
    chk(underflow_o == 1, "R7 underflow pulse", underflow_o, 1);
    chk(empty_o == 1, "R7 still empty", empty_o, 1);
    at_neg();
    chk(underflow_o == 0, "R7 pulse one cycle", underflow_o, 0);

    // R5: ack passes while not full
    irq_req_i = 1;
    #1 chk(irq_ack_o == 1, "R5 ack not full", irq_ack_o, 1);
    irq_req_i = 0;

    // R2: interleaved patterns
    do_push(13'h0101); do_push(13'h0202); do_pop();
    do_push(13'h0303); do_pop(); do_pop();
    at_neg();
    chk(empty_o == 1, "R2 empty after drain", empty_o, 1);

    // R3: fill to exactly DEPTH
    for (int i = 0; i < DEPTH; i++) do_push(AW'(13'h0400 + i));
    at_neg();
    chk(full_o == 1, "R3 full after 16", full_o, 1);
    chk(empty_o == 0, "R3 not empty", empty_o, 0);

    // R5: request held off while full
    irq_req_i = 1;
    #1 chk(irq_ack_o == 0, "R5 ack held when full", irq_ack_o, 1'b0);

    // R6: a return frees a place, request then acknowledged
    do_pop();
    at_neg();
    chk(full_o == 0, "R6 not full after pop", full_o, 0);
    chk(irq_ack_o == 1, "R6 ack after return", irq_ack_o, 1);
    do_push(13'h0777);
    at_neg();
    chk(irq_ack_o == 0, "R5 ack held again", irq_ack_o, 0);
    irq_req_i = 0;

    // R4: overflow keeps the newest 16
    for (int i = 0; i < 3; i++) do_push(AW'(13'h0900 + i));
    at_neg();
    chk(full_o == 1, "R4 full stays", full_o, 1);
    for (int i = 0; i < DEPTH; i++) do_pop();
    at_neg();
    chk(empty_o == 1, "R3 empty after full drain", empty_o, 1);

    // R7: empty pop after drain shows last popped, no state change
    do_pop();
    at_neg();
    chk(underflow_o == 1, "R7 underflow after drain", underflow_o, 1);
    chk(empty_o == 1 && full_o == 0, "R7 state unchanged", empty_o, 1);
    at_neg();
    chk(underflow_o == 0, "R7 pulse ends", underflow_o, 0);
    do_push(13'h0ABC); do_pop();
    at_neg();
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule